// File: doc/BRIEF.md
# Change-of-State Input Scanner

This block watches a bank of already-debounced digital inputs, split into byte-wide ports, and records for each port both the latest sampled value and a sticky mask of bits that have toggled since software last collected that port. A scanner steps through the ports one per clock, folding any difference between the live inputs and the held value into the change mask before taking the new value. For each port, a summary flag shows whether its change mask is non-empty, so a poller can find out where activity happened without disturbing anything.

Host reads reach the block as single-cycle strobes that an address decoder elsewhere has already qualified, each tagged with a read kind and a port index. A change read freezes the scanner, so the data value fetched afterwards comes from the same pass as the change mask. The matching data read then wipes that port's change mask and its summary flag, and sets the scanner running again. A status read only restarts a frozen scanner and never stops it. Each read is acknowledged by a one-cycle pulse once its effect on the scanner is in place.

Top module: `cos_scanner`

## Requirements
- R1: With default parameters there are four 8-bit ports. Port i is din[8i+7:8i], and its data, change mask and summary flag appear on data_o[8i+7:8i], chg_o[8i+7:8i] and flag_o[i].
- R2: While running, the scanner visits one port per clock in the order 0,1,2,3 and then repeats. A visit ORs (din slice XOR held data) into the port's change mask, so change bits stay set, and then loads the din slice into the held data.
- R3: A read with rd_kind=1 (change read) drives running_o low at the second rising edge after the strobe is sampled. While running_o is low, no port's data or change mask changes, whatever din does.
- R4: A read with rd_kind=2 (data read) clears chg_o and flag_o for port rd_port and sets running_o high at the second rising edge after the strobe. The change masks of the other ports are left as they were.
- R5: A read with rd_kind=0 (status read; code 3 acts the same) sets running_o high at the second rising edge after the strobe, whether the scanner was stopped or running, and changes no data or change mask.
- R6: flag_o[i] is high exactly when port i's change mask has at least one bit set.
- R7: While rst_n is low, all data, change masks and flags are zero and running_o is low. running_o rises at the first edge after release, and port 0 is visited at the second, so any input that is already high sets its change bit.
- R8: rd_ack is a one-cycle pulse at the second rising edge after the strobe, which is the same edge at which R3, R4 and R5 take effect.
- R9: No port is visited at the edge where a change read or a data read takes effect. The scan resumes at the port that would have been visited next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 32 | Debounced inputs, port i in bits 8i+7..8i |
| rd_req | input | 1 | One-cycle read strobe |
| rd_kind | input | 2 | 0 status, 1 change, 2 data, 3 status |
| rd_port | input | 2 | Port addressed by a data read |
| data_o | output | 32 | Held data for all ports |
| chg_o | output | 32 | Change masks for all ports |
| flag_o | output | 4 | Per-port summary flags |
| running_o | output | 1 | Scanner running |
| rd_ack | output | 1 | Read acknowledged |

## Verification
A strobe is registered at the edge that samples it, and it acts at the next edge, so running_o, rd_ack and the cleared mask are all due after two rising edges. The bench drives the strobe at a falling edge, waits through exactly those two edges, and samples on the following falling edge. A port visit lands one edge after the scanner reaches that port, and port 0 is visited two edges after reset is released. The order and stall checks therefore count single edges from a known point, while the accumulation checks wait one full pass plus margin with din held steady.

// File: rtl/cos_pkg.sv
package cos_pkg;
  typedef enum logic [1:0] {
    RD_STATUS = 2'd0,
    RD_CHANGE = 2'd1,
    RD_DATA   = 2'd2,
    RD_SPARE  = 2'd3
  } rd_kind_e;

  localparam int unsigned DEF_PORTS = 4;
  localparam int unsigned DEF_WIDTH = 8;
endpackage

// File: rtl/cos_scan_ctrl.sv
module cos_scan_ctrl #(
  parameter int unsigned PORTS = 4,
  localparam int unsigned SEL_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [1:0]       rd_kind,
  input  logic [SEL_W-1:0] rd_port,
  output logic             step_en,
  output logic [SEL_W-1:0] step_port,
  output logic             clr_en,
  output logic [SEL_W-1:0] clr_port,
  output logic             running,
  output logic             rd_ack
);
  import cos_pkg::*;

  logic             boot_q;
  logic             run_q;
  logic             pend_q;
  rd_kind_e         pkind_q;
  logic [SEL_W-1:0] pport_q;
  logic [SEL_W-1:0] ptr_q;
  logic             ack_q;

  // event wires
  logic pend_halts;
  logic pend_stops;
  assign pend_stops = pend_q && (pkind_q == RD_CHANGE);
  assign pend_halts = pend_q && ((pkind_q == RD_CHANGE) || (pkind_q == RD_DATA));

  assign step_en   = run_q && !pend_halts;
  assign step_port = ptr_q;
  assign clr_en    = pend_q && (pkind_q == RD_DATA);
  assign clr_port  = pport_q;
  assign running   = run_q;
  assign rd_ack    = ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q  <= 1'b1;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      pkind_q <= RD_STATUS;
      pport_q <= '0;
      ptr_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      boot_q  <= 1'b0;
      pend_q  <= rd_req;
      pkind_q <= rd_kind_e'(rd_kind);
      pport_q <= rd_port;
      ack_q   <= pend_q;
      if (boot_q) begin
        run_q <= 1'b1;
      end else if (pend_q) begin
        run_q <= !pend_stops;
      end
      if (step_en) begin
        if (ptr_q == SEL_W'(PORTS - 1)) ptr_q <= '0;
        else                            ptr_q <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cos_port_bank.sv
module cos_port_bank #(
  parameter int unsigned PORTS = 4,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned SEL_W = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int unsigned ALL_W = PORTS * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ALL_W-1:0] din,
  input  logic             step_en,
  input  logic [SEL_W-1:0] step_port,
  input  logic             clr_en,
  input  logic [SEL_W-1:0] clr_port,
  output logic [ALL_W-1:0] data_o,
  output logic [ALL_W-1:0] chg_o,
  output logic [PORTS-1:0] flag_o
);
  function automatic logic [WIDTH-1:0] fold_change(
    input logic [WIDTH-1:0] held,
    input logic [WIDTH-1:0] sampled,
    input logic [WIDTH-1:0] sticky
  );
    return sticky | (held ^ sampled);
  endfunction

  for (genvar g = 0; g < PORTS; g++) begin : g_port
    logic             hit;
    logic             wipe;
    logic [WIDTH-1:0] d_q;
    logic [WIDTH-1:0] c_q;
    logic             f_q;
    logic [WIDTH-1:0] merged;

    assign hit    = step_en && (step_port == SEL_W'(g));
    assign wipe   = clr_en && (clr_port == SEL_W'(g));
    assign merged = fold_change(d_q, din[g*WIDTH +: WIDTH], c_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        d_q <= '0;
        c_q <= '0;
        f_q <= 1'b0;
      end else if (wipe) begin
        c_q <= '0;
        f_q <= 1'b0;
      end else if (hit) begin
        c_q <= merged;
        d_q <= din[g*WIDTH +: WIDTH];
        f_q <= |merged;
      end
    end

    assign data_o[g*WIDTH +: WIDTH] = d_q;
    assign chg_o[g*WIDTH +: WIDTH]  = c_q;
    assign flag_o[g]                = f_q;
  end
endmodule

// File: rtl/cos_scanner.sv
module cos_scanner #(
  parameter int unsigned PORTS = cos_pkg::DEF_PORTS,
  parameter int unsigned WIDTH = cos_pkg::DEF_WIDTH,
  localparam int unsigned SEL_W = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int unsigned ALL_W = PORTS * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ALL_W-1:0] din,
  input  logic             rd_req,
  input  logic [1:0]       rd_kind,
  input  logic [SEL_W-1:0] rd_port,
  output logic [ALL_W-1:0] data_o,
  output logic [ALL_W-1:0] chg_o,
  output logic [PORTS-1:0] flag_o,
  output logic             running_o,
  output logic             rd_ack
);
  logic             step_en;
  logic [SEL_W-1:0] step_port;
  logic             clr_en;
  logic [SEL_W-1:0] clr_port;

  cos_scan_ctrl #(.PORTS(PORTS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_kind   (rd_kind),
    .rd_port   (rd_port),
    .step_en   (step_en),
    .step_port (step_port),
    .clr_en    (clr_en),
    .clr_port  (clr_port),
    .running   (running_o),
    .rd_ack    (rd_ack)
  );

  cos_port_bank #(.PORTS(PORTS), .WIDTH(WIDTH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .step_en   (step_en),
    .step_port (step_port),
    .clr_en    (clr_en),
    .clr_port  (clr_port),
    .data_o    (data_o),
    .chg_o     (chg_o),
    .flag_o    (flag_o)
  );
endmodule

// File: rtl/cos_scanner_chk.sv
module cos_scanner_chk #(
  parameter int unsigned PORTS = 4,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned SEL_W = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int unsigned ALL_W = PORTS * WIDTH
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic [1:0]       rd_kind,
  input logic [SEL_W-1:0] rd_port,
  input logic [ALL_W-1:0] data_o,
  input logic [ALL_W-1:0] chg_o,
  input logic [PORTS-1:0] flag_o,
  input logic             running_o,
  input logic             rd_ack,
  input logic             clr_en
);
  p_req_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ##2 rd_ack);

  p_change_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_kind == 2'd1) |-> ##2 !running_o);

  p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |=> $stable(data_o));

  p_status_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_kind == 2'd0) |-> ##2 running_o);

  for (genvar i = 0; i < PORTS; i++) begin : g_chk
    p_data_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_kind == 2'd2 && rd_port == SEL_W'(i))
        |-> ##2 (chg_o[i*WIDTH +: WIDTH] == '0 && !flag_o[i]));

    p_flag_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o[i] == (|chg_o[i*WIDTH +: WIDTH]));

    p_chg_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_en |=> (($past(chg_o[i*WIDTH +: WIDTH]) & ~chg_o[i*WIDTH +: WIDTH]) == '0));
  end
endmodule

bind cos_scanner cos_scanner_chk #(.PORTS(PORTS), .WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_req    (rd_req),
  .rd_kind   (rd_kind),
  .rd_port   (rd_port),
  .data_o    (data_o),
  .chg_o     (chg_o),
  .flag_o    (flag_o),
  .running_o (running_o),
  .rd_ack    (rd_ack),
  .clr_en    (clr_en)
);

// File: tb/test_cos_scanner.sv
module test_cos_scanner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] din = '0;
  logic        rd_req = 1'b0;
  logic [1:0]  rd_kind = 2'd0;
  logic [1:0]  rd_port = 2'd0;
  logic [31:0] data_o;
  logic [31:0] chg_o;
  logic [3:0]  flag_o;
  logic        running_o;
  logic        rd_ack;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_d [4];
  logic [7:0] exp_c [4];

  always #10 clk = ~clk;

  cos_scanner i_cos_scanner (
    .clk(clk), .rst_n(rst_n), .din(din), .rd_req(rd_req), .rd_kind(rd_kind),
    .rd_port(rd_port), .data_o(data_o), .chg_o(chg_o), .flag_o(flag_o),
    .running_o(running_o), .rd_ack(rd_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < 4; p++) begin
      chk(req, {24'd0, data_o[p*8 +: 8]}, {24'd0, exp_d[p]});
      chk(req, {24'd0, chg_o[p*8 +: 8]}, {24'd0, exp_c[p]});
      chk({req, "/R6"}, {31'd0, flag_o[p]}, {31'd0, |exp_c[p]});
    end
  endtask

  // one full pass with din steady, then fold expected values
  task automatic settle();
    repeat (10) @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      exp_c[p] = exp_c[p] | (exp_d[p] ^ din[p*8 +: 8]);
      exp_d[p] = din[p*8 +: 8];
    end
  endtask

  // strobe at a falling edge; returns at the falling edge after the acting edge
  task automatic read_op(input logic [1:0] kind, input logic [1:0] port);
    rd_req = 1'b1; rd_kind = kind; rd_port = port;
    @(posedge clk); @(negedge clk);
    rd_req = 1'b0;
    chk("R8 ack early", {31'd0, rd_ack}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R8 ack due", {31'd0, rd_ack}, 32'd1);
  endtask

  task automatic do_reset(input logic [31:0] val);
    @(negedge clk);
    rst_n = 1'b0; din = val;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 4; p++) begin exp_d[p] = '0; exp_c[p] = '0; end
  endtask

  task automatic t_reset_r7();
    do_reset(32'hC35A0F81);
    chk("R7 data zero", data_o, 32'd0);
    chk("R7 chg zero", chg_o, 32'd0);
    chk("R7 flags zero", {28'd0, flag_o}, 32'd0);
    chk("R7 stopped", {31'd0, running_o}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 running after release", {31'd0, running_o}, 32'd1);
    chk("R7 no visit yet", data_o, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R2 port0 first", data_o, 32'h00000081);
    chk("R7 on-input sets change", chg_o, 32'h00000081);
    @(posedge clk); @(negedge clk);
    chk("R2 port1 second", data_o, 32'h00000F81);
    settle();
    check_all("R1 R7 full pass");
  endtask

  task automatic t_accum_r2();
    for (int p = 0; p < 4; p++) begin
      read_op(2'd2, 2'(p));
      exp_c[p] = '0;
      chk("R4 clear after data read", {24'd0, chg_o[p*8 +: 8]}, 32'd0);
    end
    din = din ^ 32'h10000102;
    settle();
    check_all("R2 accumulate");
    din = din ^ 32'h00000002;
    settle();
    check_all("R2 sticky after revert");
  endtask

  task automatic t_stop_r3();
    logic [31:0] old_d, old_c;
    read_op(2'd1, 2'd0);
    chk("R3 stopped", {31'd0, running_o}, 32'd0);
    old_d = data_o; old_c = chg_o;
    din = ~din;
    repeat (10) @(negedge clk);
    chk("R3 data frozen", data_o, old_d);
    chk("R3 chg frozen", chg_o, old_c);
    chk("R3 still stopped", {31'd0, running_o}, 32'd0);
    read_op(2'd2, 2'd2);
    exp_c[2] = '0;
    chk("R4 port2 chg cleared", {24'd0, chg_o[23:16]}, 32'd0);
    chk("R4 port2 flag cleared", {31'd0, flag_o[2]}, 32'd0);
    chk("R4 others kept", {chg_o[31:24], chg_o[15:0]}, {8'd0, old_c[31:24], old_c[15:0]});
    chk("R4 restarted", {31'd0, running_o}, 32'd1);
    @(negedge clk);
    chk("R8 ack one cycle", {31'd0, rd_ack}, 32'd0);
    settle();
    check_all("R4 after restart");
  endtask

  task automatic t_status_r5();
    logic [31:0] old_c;
    read_op(2'd1, 2'd1);
    chk("R3 stopped by change read", {31'd0, running_o}, 32'd0);
    old_c = chg_o;
    read_op(2'd0, 2'd0);
    chk("R5 status restarts", {31'd0, running_o}, 32'd1);
    chk("R5 chg untouched", chg_o, old_c);
    read_op(2'd3, 2'd1);
    chk("R5 status while running", {31'd0, running_o}, 32'd1);
    chk("R5 chg untouched running", chg_o, old_c);
  endtask

  task automatic t_stall_r9();
    do_reset(32'h11111111);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    read_op(2'd1, 2'd0);
    chk("R9 port0 visited", data_o, 32'h00000011);
    chk("R3 stopped early", {31'd0, running_o}, 32'd0);
    read_op(2'd2, 2'd2);
    chk("R9 no visit at acting edge", data_o, 32'h00000011);
    @(posedge clk); @(negedge clk);
    chk("R9 resumes at port1", data_o, 32'h00001111);
  endtask

  initial begin
    t_reset_r7();
    t_accum_r2();
    t_stop_r3();
    t_status_r5();
    t_stall_r9();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule